// File: doc/BRIEF.md
# Write-Path Coherence Controller for a Private Cache

This block serves processor store requests for one private cache kept coherent by a four-state (Invalid, Shared, Exclusive, Modified) protocol. For each store it reads the tag match and the line state from an external state array, then sorts the store into one of four outcomes: a miss, a store to a Shared line, a silent upgrade of an Exclusive line, or a plain hit on a Modified line. A miss can be a tag mismatch or a matching line that is Invalid. When other caches may hold the line, the block asks the bus to invalidate it and waits for the acknowledge. After that it installs or upgrades the line to Modified through a write port on the state array.

The control is a three-state machine. IDLE looks at the request and the lookup result in the same cycle. IDLE stays in IDLE for a store to an Exclusive or Modified line, or when no request is present. IDLE goes to INVAL for a miss or a store to a Shared line. INVAL holds the bus request and stays in INVAL until the acknowledge arrives, then goes to COMMIT. COMMIT writes Modified into the state array, completes the handshake and always returns to IDLE.

Five saturating event counters are visible as outputs. They count misses, misses on an Invalid line, hits, stores to Shared lines, and invalidates sent.

Top module: `mesi_write_ctrl`

## Requirements
- R1: Line states use the 2-bit encoding Invalid=00, Shared=01, Exclusive=10, Modified=11, on both `lk_state` and `upd_state`.
- R2: After reset every counter reads 0, and `inv_req`, `upd_en` and `wr_ready` are low.
- R3: A store with `lk_tag_hit` low is a miss. It adds 1 to `cnt_miss`, raises `inv_req` the cycle after it is seen, and ends with the line written as Modified.
- R4: A store whose tag matches a line in state Invalid is also a miss. It adds 1 to both `cnt_miss` and `cnt_on_inval`, and follows the same invalidate-then-install sequence as R3.
- R5: A store to a Shared line adds 1 to `cnt_hit` and 1 to `cnt_on_shared`. It sends an invalidate, then writes the line as Modified.
- R6: A store to an Exclusive line adds 1 to `cnt_hit`. In the same cycle it raises `wr_ready` and `upd_en` with `upd_state`=Modified, with no `inv_req`.
- R7: A store to a Modified line adds 1 to `cnt_hit` and raises `wr_ready` in the same cycle, with neither `upd_en` nor `inv_req`.
- R8: While `inv_req` is high and `inv_ack` is low, `inv_req` stays high, `inv_addr` stays stable, and `wr_ready` and `upd_en` stay low.
- R9: The cycle after `inv_req` and `inv_ack` are both high, `upd_en` and `wr_ready` are high for one cycle, with `upd_state`=Modified and `upd_addr` equal to the store address.
- R10: Each acknowledged invalidate adds 1 to `cnt_inv_sent`.
- R11: Every counter is CNT_W bits wide (32 by default) and holds at 2^CNT_W-1 instead of wrapping.
- R12: While `wr_valid` is low, no counter changes and `upd_en` and `inv_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Store request present |
| wr_addr | input | AW | Store address |
| wr_ready | output | 1 | Store completed this cycle |
| lk_addr | output | AW | Address presented to the state array |
| lk_tag_hit | input | 1 | Tag matched in the state array |
| lk_state | input | 2 | State of the matching line |
| upd_en | output | 1 | Write enable for the state array |
| upd_addr | output | AW | Address of the line to update |
| upd_state | output | 2 | New state to write |
| inv_req | output | 1 | Bus invalidate request |
| inv_addr | output | AW | Address to invalidate |
| inv_ack | input | 1 | Bus invalidate acknowledge |
| cnt_miss | output | CNT_W | Store misses |
| cnt_on_inval | output | CNT_W | Misses on a matching Invalid line |
| cnt_hit | output | CNT_W | Store hits (Shared, Exclusive, Modified) |
| cnt_on_shared | output | CNT_W | Stores to Shared lines |
| cnt_inv_sent | output | CNT_W | Invalidates acknowledged |

## Verification
The hardest case to reach from the ports is counter saturation. With 32-bit counters it cannot be reached in a short run, so the bench builds the block with a 4-bit counter width and sends more than fifteen stores of each kind, then checks that every counter stays at its top value. A second hard case is the timing of the acknowledge. The bench varies the acknowledge delay, including an acknowledge in the very first cycle of the request, and checks that the state array is never written before the acknowledge arrives.

// File: rtl/mesi_wr_pkg.sv
package mesi_wr_pkg;
    typedef enum logic [1:0] {
        LN_I = 2'b00,
        LN_S = 2'b01,
        LN_E = 2'b10,
        LN_M = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INVAL  = 2'd1,
        ST_COMMIT = 2'd2
    } ctl_st_t;
endpackage

// File: rtl/mesi_wr_classify.sv
module mesi_wr_classify
    import mesi_wr_pkg::*;
(
    input  logic     tag_hit,
    input  line_st_t state,
    output logic     is_miss,
    output logic     on_invalid,
    output logic     is_hit,
    output logic     on_shared,
    output logic     need_inv,
    output logic     silent_up
);
    always_comb begin
        is_miss    = !tag_hit || (state == LN_I);
        on_invalid = tag_hit && (state == LN_I);
        is_hit     = !is_miss;
        on_shared  = tag_hit && (state == LN_S);
        need_inv   = is_miss || on_shared;
        silent_up  = tag_hit && (state == LN_E);
    end
endmodule

// File: rtl/mesi_sat_cnt.sv
module mesi_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end

    // R11: a full counter never wraps
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV) |=> (cnt == MAXV));
endmodule

// File: rtl/mesi_write_ctrl.sv
module mesi_write_ctrl
    import mesi_wr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    output logic             wr_ready,
    output logic [AW-1:0]    lk_addr,
    input  logic             lk_tag_hit,
    input  logic [1:0]       lk_state,
    output logic             upd_en,
    output logic [AW-1:0]    upd_addr,
    output logic [1:0]       upd_state,
    output logic             inv_req,
    output logic [AW-1:0]    inv_addr,
    input  logic             inv_ack,
    output logic [CNT_W-1:0] cnt_miss,
    output logic [CNT_W-1:0] cnt_on_inval,
    output logic [CNT_W-1:0] cnt_hit,
    output logic [CNT_W-1:0] cnt_on_shared,
    output logic [CNT_W-1:0] cnt_inv_sent
);
    localparam int NCNT = 5;

    ctl_st_t       st_q, st_d;
    logic [AW-1:0] addr_q;
    logic          c_miss, c_oninv, c_hit, c_onsh, c_needinv, c_silent;
    logic          take;
    logic [NCNT-1:0]       inc_v;
    logic [CNT_W-1:0]      cnt_v [NCNT];

    mesi_wr_classify u_cls (
        .tag_hit    (lk_tag_hit),
        .state      (line_st_t'(lk_state)),
        .is_miss    (c_miss),
        .on_invalid (c_oninv),
        .is_hit     (c_hit),
        .on_shared  (c_onsh),
        .need_inv   (c_needinv),
        .silent_up  (c_silent)
    );

    assign take    = (st_q == ST_IDLE) && wr_valid;
    assign lk_addr = wr_addr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
        end else begin
            st_q <= st_d;
            if (take && c_needinv)
                addr_q <= wr_addr;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (take && c_needinv) st_d = ST_INVAL;
            ST_INVAL:  if (inv_ack)           st_d = ST_COMMIT;
            ST_COMMIT:                        st_d = ST_IDLE;
            default:                          st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_ready  = 1'b0;
        upd_en    = 1'b0;
        upd_addr  = addr_q;
        upd_state = LN_M;
        inv_req   = 1'b0;
        inv_addr  = addr_q;
        unique case (st_q)
            ST_IDLE: begin
                upd_addr = wr_addr;
                if (take && !c_needinv) begin
                    wr_ready = 1'b1;
                    upd_en   = c_silent;
                end
            end
            ST_INVAL:  inv_req = 1'b1;
            ST_COMMIT: begin
                upd_en   = 1'b1;
                wr_ready = 1'b1;
            end
            default: ;
        endcase
    end

    assign inc_v[0] = take && c_miss;
    assign inc_v[1] = take && c_oninv;
    assign inc_v[2] = take && c_hit;
    assign inc_v[3] = take && c_onsh;
    assign inc_v[4] = inv_req && inv_ack;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        mesi_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_v[g]),
            .cnt   (cnt_v[g])
        );
    end

    assign cnt_miss      = cnt_v[0];
    assign cnt_on_inval  = cnt_v[1];
    assign cnt_hit       = cnt_v[2];
    assign cnt_on_shared = cnt_v[3];
    assign cnt_inv_sent  = cnt_v[4];

    // R8: a pending invalidate holds with a stable address
    a_r8_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !inv_ack) |=> (inv_req && $stable(inv_addr)));

    // R8: no completion and no array write while invalidate is pending
    a_r8_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> (!wr_ready && !upd_en));

    // R9: acknowledged invalidate commits Modified on the next cycle
    a_r9_commit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && inv_ack) |=> (upd_en && wr_ready && upd_state == 2'b11));

    // R10: acknowledged invalidate is counted
    a_r10_inv_count: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && inv_ack) |=>
        ((cnt_inv_sent == CNT_W'($past(cnt_inv_sent) + 1'b1)) || (&$past(cnt_inv_sent))));

    // R12: no request, no counter motion
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !inv_req && !upd_en) |=> $stable(cnt_hit) && $stable(cnt_miss));
endmodule

// File: tb/sim_mesi_write_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_write_ctrl;
    localparam int  AW    = 16;
    localparam int  CW    = 4;
    localparam time TCLK  = 10;
    localparam int  CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic wr_ready;
    logic [AW-1:0] lk_addr;
    logic lk_tag_hit = 1'b0;
    logic [1:0] lk_state = 2'b00;
    logic upd_en;
    logic [AW-1:0] upd_addr;
    logic [1:0] upd_state;
    logic inv_req;
    logic [AW-1:0] inv_addr;
    logic inv_ack = 1'b0;
    logic [CW-1:0] cnt_miss, cnt_on_inval, cnt_hit, cnt_on_shared, cnt_inv_sent;

    int n_tests = 0;
    int n_fail  = 0;
    int m_miss = 0, m_oninv = 0, m_hit = 0, m_onsh = 0, m_inv = 0;
    bit done = 0;

    always #(TCLK/2) clk = ~clk;

    mesi_write_ctrl #(.AW(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_ready(wr_ready), .lk_addr(lk_addr), .lk_tag_hit(lk_tag_hit),
        .lk_state(lk_state), .upd_en(upd_en), .upd_addr(upd_addr),
        .upd_state(upd_state), .inv_req(inv_req), .inv_addr(inv_addr),
        .inv_ack(inv_ack), .cnt_miss(cnt_miss), .cnt_on_inval(cnt_on_inval),
        .cnt_hit(cnt_hit), .cnt_on_shared(cnt_on_shared), .cnt_inv_sent(cnt_inv_sent)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic chk_counts(input string req);
        chk({req, " cnt_miss"},      cnt_miss,      sat(m_miss));
        chk({req, " cnt_on_inval"},  cnt_on_inval,  sat(m_oninv));
        chk({req, " cnt_hit"},       cnt_hit,       sat(m_hit));
        chk({req, " cnt_on_shared"}, cnt_on_shared, sat(m_onsh));
        chk({req, " cnt_inv_sent"},  cnt_inv_sent,  sat(m_inv));
    endtask

    // one store; st uses R1 encoding I=0 S=1 E=2 M=3
    task automatic do_store(input logic [AW-1:0] a, input bit hit,
                            input logic [1:0] st, input int ack_dly);
        bit needinv;
        needinv = !hit || st == 2'b00 || st == 2'b01;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; lk_tag_hit = hit; lk_state = st;
        #1;
        chk("R1 lk_addr", lk_addr, a);
        if (!needinv) begin
            chk(st == 2'b10 ? "R6 ready" : "R7 ready", wr_ready, 1);
            chk(st == 2'b10 ? "R6 no inv" : "R7 no inv", inv_req, 0);
            chk(st == 2'b10 ? "R6 upd_en" : "R7 upd_en", upd_en, st == 2'b10);
            if (st == 2'b10) begin
                chk("R6 upd_state M", upd_state, 2'b11);
                chk("R6 upd_addr", upd_addr, a);
            end
            m_hit++;
        end else begin
            chk("R8 not ready on lookup", wr_ready, 0);
            if (!hit || st == 2'b00) m_miss++;
            if (hit && st == 2'b00) m_oninv++;
            if (hit && st == 2'b01) begin m_hit++; m_onsh++; end
            @(negedge clk);
            wr_valid = 1'b1;
            lk_tag_hit = 1'b0; lk_state = 2'b11;  // lookup is not used after the first cycle
            chk(hit && st == 2'b01 ? "R5 inv_req" : (hit ? "R4 inv_req" : "R3 inv_req"), inv_req, 1);
            chk("R8 inv_addr", inv_addr, a);
            for (int i = 0; i < ack_dly; i++) begin
                chk("R8 held no upd", upd_en, 0);
                chk("R8 held no ready", wr_ready, 0);
                @(negedge clk);
                chk("R8 inv held", inv_req, 1);
                chk("R8 inv_addr stable", inv_addr, a);
            end
            inv_ack = 1'b1;
            @(negedge clk);
            inv_ack = 1'b0;
            m_inv++;
            #1;
            chk("R9 upd_en", upd_en, 1);
            chk("R9 upd_state M", upd_state, 2'b11);
            chk("R9 upd_addr", upd_addr, a);
            chk("R9 ready", wr_ready, 1);
            chk("R9 inv dropped", inv_req, 0);
        end
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        chk("R12 no upd when idle", upd_en, 0);
        chk_counts("R10/R3-R7 counters");
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 cnt_miss", cnt_miss, 0);
        chk("R2 cnt_hit", cnt_hit, 0);
        chk("R2 cnt_inv_sent", cnt_inv_sent, 0);
        chk("R2 inv_req", inv_req, 0);
        chk("R2 upd_en", upd_en, 0);
        chk("R2 wr_ready", wr_ready, 0);

        do_store(16'h1230, 1'b0, 2'b00, 2);   // R3 tag miss
        do_store(16'h2000, 1'b1, 2'b00, 0);   // R4 invalid line, ack at once
        do_store(16'h3040, 1'b1, 2'b01, 3);   // R5 shared
        do_store(16'h4400, 1'b1, 2'b10, 0);   // R6 exclusive
        do_store(16'h5550, 1'b1, 2'b11, 0);   // R7 modified

        // R12: lookup inputs wiggle with no request
        lk_tag_hit = 1'b1; lk_state = 2'b01;
        repeat (4) begin
            @(negedge clk);
            #1;
            chk("R12 no inv_req", inv_req, 0);
            chk("R12 no upd_en", upd_en, 0);
        end
        chk_counts("R12 counters idle");

        // R11 saturation with narrow counters
        for (int k = 0; k < 20; k++) begin
            do_store(AW'(16'h0100 + k), 1'b1, 2'b11, 0);
            do_store(AW'(16'h0200 + k), 1'b1, 2'b00, k % 3);
            do_store(AW'(16'h0300 + k), 1'b1, 2'b01, 1);
        end
        chk("R11 hit saturated", cnt_hit, CMAX);
        chk("R11 miss saturated", cnt_miss, CMAX);
        chk("R11 on_inval saturated", cnt_on_inval, CMAX);
        chk("R11 on_shared saturated", cnt_on_shared, CMAX);
        chk("R11 inv_sent saturated", cnt_inv_sent, CMAX);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule